// File: doc/BRIEF.md
# Recursive Vertical-and-Crosswise Multiplier

This block multiplies two unsigned N-bit operands and returns their full 2N-bit product with no clock and no state. The output follows the inputs within the same evaluation. It is meant to sit inside a larger datapath, which places registers around it as its timing requires. The usual sizes are N = 8, giving a 16-bit product, and N = 16, giving a 32-bit product. Any power of two from 2 upward builds.

The structure is recursive. The leaf is a 2x2 cell that forms its four product bits directly from the two vertical terms and the cross terms. Each level above the leaf splits both operands into a low half and a high half and multiplies them in four half-width sub-multipliers: low by low, high by low, low by high and high by high. Each of these results is N bits wide. The level places the four terms in a 2N-bit frame by padding with zeros: low by low at bit 0, the two cross terms at bit N/2, and high by high at bit N. Two 3:2 carry-save rows reduce the four terms to one sum vector and one carry vector. A single carry-propagate addition then gives that level's product.

The block has no handshake. Data enters and leaves as plain levels, so back-pressure does not apply.

Top module: `vedic_mult`

## Requirements
- R1: For every pair of unsigned operands, `prod` equals the arithmetic product `op_a * op_b` in 2N bits. The N = 8 configuration is tried on all 65536 operand pairs.
- R2: When either operand is zero, `prod` is zero.
- R3: When one operand is 1, `prod` equals the other operand extended with zeros to 2N bits.
- R4: When both operands are all ones, `prod` equals 2^(2N) - 2^(N+1) + 1. The most significant product bit is then 1 and bit 0 is 1.
- R5: When the most significant bit of either operand is 0, the most significant product bit, bit 2N-1, is 0. No carry is lost at the top of the 2N-bit frame.
- R6: The N = 16 configuration gives the correct 32-bit product for the corner operands 0, 1, 0x8000 and 0xFFFF and for random operands.
- R7: The N = 2 configuration, which is the bare base cell, gives the correct 4-bit product for all 16 operand pairs.
- R8: The block is combinational. A change on either operand is visible on `prod` one time unit later, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | Unsigned multiplicand |
| op_b | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product |

## Verification
The N = 8 instance is swept over every operand pair. This exposes any fault in the placement of a cross term or in a carry-save bit, because such a fault shows up as a wrong bit for some operand pair. Directed operands (zero, one, all ones, and the single top bit) isolate zero padding, identity passing and the largest product, where the top carry has no room to spare. On the 16-bit instance, random operands with a fixed seed reach the deeper recursion, where an exhaustive sweep is too large. The bare 2x2 cell is swept on its own, so that a fault in the leaf is told apart from a fault in the combining logic.

// File: rtl/vm_pkg.sv
package vm_pkg;
  // Width of the leaf multiplier cell
  localparam int unsigned LEAF_W = 2;

  // True when w is a power of two at least as large as the leaf
  function automatic bit width_ok(input int unsigned w);
    return (w >= LEAF_W) && ((w & (w - 1)) == 0);
  endfunction
endpackage

// File: rtl/vm_cell2.sv
module vm_cell2 (
  input  logic [1:0] x,
  input  logic [1:0] y,
  output logic [3:0] z
);
  logic v0, v1, k0, k1, hi, cx;

  always_comb begin
    v0   = x[0] & y[0];
    v1   = x[1] & y[1];
    k0   = x[1] & y[0];
    k1   = x[0] & y[1];
    cx   = k0 & k1;
    hi   = v1 ^ cx;
    z[0] = v0;
    z[1] = k0 ^ k1;
    z[2] = hi;
    z[3] = v1 & cx;
  end
endmodule

// File: rtl/vm_csa.sv
module vm_csa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] in0,
  input  logic [W-1:0] in1,
  input  logic [W-1:0] in2,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  logic [W-1:0] maj;

  always_comb begin
    sum_o = in0 ^ in1 ^ in2;
    maj   = (in0 & in1) | (in0 & in2) | (in1 & in2);
    // carry weight is one bit up; the top majority bit cannot be set
    // for a sum that fits the frame, so the shift is exact
    cry_o = {maj[W-2:0], 1'b0};
  end
endmodule

// File: rtl/vm_node.sv
module vm_node #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   x,
  input  logic [N-1:0]   y,
  output logic [2*N-1:0] z
);
  generate
    if (N == vm_pkg::LEAF_W) begin : g_leaf
      vm_cell2 u_cell (.x(x), .y(y), .z(z));
    end else begin : g_split
      localparam int unsigned H = N / 2;
      localparam int unsigned W = 2 * N;

      logic [N-1:0] t_ll, t_hl, t_lh, t_hh;
      logic [W-1:0] f0, f1, f2, f3;
      logic [W-1:0] s_a, c_a, s_b, c_b;

      vm_node #(.N(H)) u_ll (.x(x[H-1:0]), .y(y[H-1:0]), .z(t_ll));
      vm_node #(.N(H)) u_hl (.x(x[N-1:H]), .y(y[H-1:0]), .z(t_hl));
      vm_node #(.N(H)) u_lh (.x(x[H-1:0]), .y(y[N-1:H]), .z(t_lh));
      vm_node #(.N(H)) u_hh (.x(x[N-1:H]), .y(y[N-1:H]), .z(t_hh));

      // align the quadrant terms in the 2N-bit frame with zero padding
      assign f0 = {{N{1'b0}}, t_ll};
      assign f1 = {{H{1'b0}}, t_hl, {H{1'b0}}};
      assign f2 = {{H{1'b0}}, t_lh, {H{1'b0}}};
      assign f3 = {t_hh, {N{1'b0}}};

      vm_csa #(.W(W)) u_row0 (.in0(f0),  .in1(f1),  .in2(f2),
                              .sum_o(s_a), .cry_o(c_a));
      vm_csa #(.W(W)) u_row1 (.in0(s_a), .in1(c_a), .in2(f3),
                              .sum_o(s_b), .cry_o(c_b));

      // single carry-propagate merge of the redundant pair
      assign z = s_b + c_b;
    end
  endgenerate
endmodule

// File: rtl/vedic_mult.sv
module vedic_mult #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic [2*N-1:0] prod
);
  vm_node #(.N(N)) u_root (.x(op_a), .y(op_b), .z(prod));
endmodule

// File: rtl/vedic_mult_chk.sv
module vedic_mult_chk #(
  parameter int unsigned N = 8
) (
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic [2*N-1:0] prod
);
  localparam int unsigned W = 2 * N;

  always_comb begin
    // R1
    prod_match_chk: assert (prod == (W'(op_a) * W'(op_b)));
    // R2
    zero_op_chk: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0));
    // R3
    unit_op_chk: assert (!(op_b == N'(1)) || (prod == W'(op_a)));
    // R5
    no_overflow_chk: assert ((op_a[N-1] && op_b[N-1]) || !prod[W-1]);
  end
endmodule

bind vedic_mult vedic_mult_chk #(.N(N)) u_chk (.op_a(op_a), .op_b(op_b), .prod(prod));

// File: tb/tb_vedic_mult.sv
module tb_vedic_mult;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;

  vedic_mult #(.N(8))  dut   (.op_a(a8),  .op_b(b8),  .prod(p8));
  vedic_mult #(.N(16)) dut16 (.op_a(a16), .op_b(b16), .prod(p16));
  vedic_mult #(.N(2))  dut2  (.op_a(a2),  .op_b(b2),  .prod(p2));

  // shift-and-add reference
  function automatic logic [31:0] ref_mul(input logic [15:0] x, input logic [15:0] y);
    logic [31:0] acc = '0;
    for (int i = 0; i < 16; i++)
      if (y[i]) acc = acc + ({16'b0, x} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic t8(input string req, input logic [7:0] x, input logic [7:0] y);
    a8 = x; b8 = y; #1;
    check(req, {16'b0, p8}, ref_mul({8'b0, x}, {8'b0, y}));
  endtask

  task automatic t16(input string req, input logic [15:0] x, input logic [15:0] y);
    a16 = x; b16 = y; #1;
    check(req, p16, ref_mul(x, y));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    a8 = '0; b8 = '0; a16 = '0; b16 = '0; a2 = '0; b2 = '0;
    #1;
    // R2 idle state with zero inputs
    check("R2", {16'b0, p8}, 32'd0);
    check("R2", p16, 32'd0);

    // R7 leaf cell exhaustive
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        a2 = 2'(i); b2 = 2'(j); #1;
        check("R7", {28'b0, p2}, 32'(i * j));
      end

    // R2, R3, R4, R5 directed on N=8
    t8("R2", 8'h00, 8'hA7);
    t8("R2", 8'h5C, 8'h00);
    t8("R3", 8'h01, 8'hD3);
    t8("R3", 8'hB9, 8'h01);
    a8 = 8'hFF; b8 = 8'hFF; #1;
    check("R4", {16'b0, p8}, 32'hFE01);
    check("R4", {31'b0, p8[15] & p8[0]}, 32'd1);
    a8 = 8'h7F; b8 = 8'hFF; #1;
    check("R5", {31'b0, p8[15]}, 32'd0);

    // R8 output follows an operand change without a clock edge
    @(negedge clk);
    a8 = 8'd13; b8 = 8'd11; #1;
    check("R8", {16'b0, p8}, 32'd143);
    b8 = 8'd200; #1;
    check("R8", {16'b0, p8}, 32'd2600);

    // R1 exhaustive sweep of N=8
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        t8("R1", 8'(i), 8'(j));

    // R6 corners and random on N=16
    t16("R6", 16'h0000, 16'hFFFF);
    t16("R6", 16'h0001, 16'hBEEF);
    t16("R6", 16'h8000, 16'h8000);
    t16("R6", 16'hFFFF, 16'hFFFF);
    t16("R6", 16'hFFFF, 16'h0001);
    a16 = 16'hFFFF; b16 = 16'hFFFF; #1;
    check("R4", p16, 32'hFFFE0001);
    for (int k = 0; k < 4000; k++)
      t16("R6", 16'($urandom), 16'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule